// File: doc/BRIEF.md
# Serial Configuration Register Port

This block gives a host controller read and write access to a bank of 32 eight-bit configuration registers over a bit-banged serial link with a clock (SCLK), an active-low select (CSB) and data pins. Every access cycle opens with one instruction byte. That byte names the direction, a burst length of one to four bytes and a 5-bit start address. The data bytes that follow go to, or come from, a run of neighbouring addresses.

The port's own settings sit in register 00h. These settings are the bit order, the wire mode and a self-clearing software reset. A change written there applies to the bits that follow in the same cycle. In 4-wire mode read data leaves on a dedicated output. In 3-wire mode the data pin turns around for reads and the dedicated output stays undriven. All serial pins are oversampled by the core clock. The full register contents are presented as a flat bus to the datapath.

Top module: `spi_reg_port`

## Requirements
- R1: The instruction byte is the first eight bits after CSB falls. Its bit 7 selects read (1) or write (0). Its bits 6:5 give the byte count minus one (00 = 1 byte up to 11 = 4 bytes). Its bits 4:0 give the start address. Input bits are taken on rising SCLK edges.
- R2: In a write cycle, each data byte is stored into its register once the 8th bit of that byte has been received. The bytes of a multi-byte write land at successive addresses.
- R3: With register 00h bit 6 = 0, every byte travels MSB first. The address steps down by one after each data byte and wraps from 00h to 1Fh.
- R4: With register 00h bit 6 = 1, every byte travels LSB first. The address steps up by one after each data byte and wraps from 1Fh to 00h.
- R5: In a read cycle, output bits change on falling SCLK edges. The first data bit appears after the falling edge that follows the 8th instruction bit. Each byte returns the current contents of its register.
- R6: With register 00h bit 7 = 0 (4-wire), read data is driven on sdo_out, sdo_oe is high while CSB is low, and sdio_oe stays low. With bit 7 = 1 (3-wire), read data is driven on sdio_out, sdio_oe is high during the read data bits, and sdo_oe stays low.
- R7: CSB going high ends the cycle. A byte that is not yet complete is discarded. The next cycle starts again with an instruction byte.
- R8: While CSB is high, both sdo_oe and sdio_oe are low.
- R9: A write with register 00h bit 5 = 1 clears registers 01h to 1Fh to 00h. Register 00h keeps the other bits of that byte, and its bit 5 always reads 0.
- R10: A low level on rst_n clears all 32 registers, including 00h.
- R11: Register 00h bit 1 reads back the lock_in input. Writes to that bit are ignored and it is never stored.
- R12: A bit-order change written to 00h governs all later bits of the same cycle. The address step right after that byte still follows the old order.
- R13: Bits sent after the counted number of data bytes are ignored until CSB rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low cycle select |
| sdio_in | input | 1 | Serial data input (pad input of the data pin) |
| sdio_out | output | 1 | Read data toward the data pin in 3-wire mode |
| sdio_oe | output | 1 | Drive enable for the data pin |
| sdo_out | output | 1 | Read data on the dedicated output in 4-wire mode |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| lock_in | input | 1 | External lock status mirrored in register 00h bit 1 |
| cfg_o | output | 256 | Stored register contents, register n at bits n*8+7:n*8 |

## Verification
The bench uses the default build: two synchronizer stages and the full 32-entry, 8-bit bank. At that size every register can be written and read back in both bit orders, using bursts that sweep the whole address space. Both wrap points, 00h to 1Fh and 1Fh to 00h, are crossed with real data. Register 00h sits inside those sweeps, so mid-cycle order changes, software reset and the read-only lock bit are all reached at their true addresses.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int CNT_W     = 2;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int BIT_W     = $clog2(DATA_W);

  // control register 0 bit positions
  localparam int TW_BIT    = 7;
  localparam int LSB_BIT   = 6;
  localparam int SRST_BIT  = 5;
  localparam int LOCK_BIT  = 1;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_t;

  typedef struct packed {
    logic              rd;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csb,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_pipe, csb_pipe, sdi_pipe;
  logic              sclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      csb_pipe  <= '1;
      sdi_pipe  <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
      csb_pipe  <= {csb_pipe[STAGES-2:0], csb};
      sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi};
      sclk_last <= sclk_pipe[STAGES-1];
    end
  end

  assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_last;
  assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_last;
  assign cs_act    = ~csb_pipe[STAGES-1];
  assign sdi_s     = sdi_pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              rd_phase
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_t             phase_q, phase_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               rd_q, rd_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  rbyte_q, rbyte_d;
  logic               dout_q, dout_d;
  logic               wen_q, wen_d;
  logic [ADDR_W-1:0]  waddr_q, waddr_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;

  logic [DATA_W-1:0]  asm_byte;
  logic [DATA_W-1:0]  tx_byte;
  logic [BIT_W-1:0]   tx_idx;
  logic [ADDR_W-1:0]  addr_step;
  logic               step_en;
  instr_t             ins;

  always_comb begin
    asm_byte  = lsb_first ? {sdi, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], sdi};
    ins       = instr_t'(asm_byte);
    addr_step = lsb_first ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
    tx_byte   = (bit_q == '0) ? rd_data : rbyte_q;
    tx_idx    = lsb_first ? bit_q : LAST_BIT - bit_q;
    step_en   = sclk_rise | sclk_fall | ~cs_act;
  end

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    left_d  = left_q;
    addr_d  = addr_q;
    rbyte_d = rbyte_q;
    dout_d  = dout_q;
    wen_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (!cs_act) begin
      phase_d = PH_INSTR;
      bit_d   = '0;
    end else if (sclk_rise && phase_q != PH_DONE) begin
      sh_d  = asm_byte;
      bit_d = bit_q + BIT_W'(1);
      if (bit_q == LAST_BIT) begin
        if (phase_q == PH_INSTR) begin
          rd_d    = ins.rd;
          left_d  = ins.cnt;
          addr_d  = ins.addr;
          phase_d = PH_DATA;
        end else begin
          if (!rd_q) begin
            wen_d   = 1'b1;
            waddr_d = addr_q;
            wdata_d = asm_byte;
          end
          addr_d = addr_step;
          if (left_q == '0) phase_d = PH_DONE;
          else              left_d  = left_q - CNT_W'(1);
        end
      end
    end else if (sclk_fall && phase_q == PH_DATA && rd_q) begin
      if (bit_q == '0) rbyte_d = rd_data;
      dout_d = tx_byte[tx_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bit_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      rbyte_q <= '0;
      dout_q  <= 1'b0;
    end else if (step_en) begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
      rbyte_q <= rbyte_d;
      dout_q  <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wen_q <= wen_d;
      if (wen_d) begin
        waddr_q <= waddr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign wr_en    = wen_q;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;
  assign rd_addr  = addr_q;
  assign dout     = dout_q;
  assign rd_phase = (phase_q == PH_DATA) && rd_q;
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank
  import spi_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic                       lock_in,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam logic [DATA_W-1:0] RO_MASK =
    (DATA_W'(1) << SRST_BIT) | (DATA_W'(1) << LOCK_BIT);
  localparam logic [DATA_W-1:0] DEF_VAL = '0;

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic [DATA_W-1:0] view0;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
    if (wr_addr == '0) begin
      if (wr_data[SRST_BIT]) begin
        for (int i = 1; i < NUM_REGS; i++) regs_d[i] = DEF_VAL;
      end
      regs_d[0] = wr_data & ~RO_MASK;
    end else begin
      regs_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= DEF_VAL;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    view0           = regs_q[0];
    view0[LOCK_BIT] = lock_in;
    rd_data         = (rd_addr == '0) ? view0 : regs_q[rd_addr];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end
endmodule

// File: rtl/spi_reg_port.sv
`timescale 1ns/1ps
module spi_reg_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       csb,
  input  logic                       sdio_in,
  output logic                       sdio_out,
  output logic                       sdio_oe,
  output logic                       sdo_out,
  output logic                       sdo_oe,
  input  logic                       lock_in,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              sclk_rise, sclk_fall, cs_act, sdi_s;
  logic              wr_en, dout, rd_phase;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              three_wire, lsb_first;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk      (sclk),
    .csb       (csb),
    .sdi       (sdio_in),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .sdi_s     (sdi_s)
  );

  spi_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .sdi       (sdi_s),
    .lsb_first (lsb_first),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .dout      (dout),
    .rd_phase  (rd_phase)
  );

  spi_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .lock_in   (lock_in),
    .rd_data   (rd_data),
    .regs_flat (cfg_o)
  );

  assign three_wire = cfg_o[TW_BIT];
  assign lsb_first  = cfg_o[LSB_BIT];
  assign sdo_out    = dout;
  assign sdio_out   = dout;
  assign sdo_oe     = ~csb & ~three_wire;
  assign sdio_oe    = ~csb & three_wire & rd_phase;
endmodule

// File: rtl/spi_reg_port_chk.sv
`timescale 1ns/1ps
module spi_reg_port_chk
  import spi_port_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csb,
  input logic                       sdo_oe,
  input logic                       sdio_oe,
  input logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  logic [2:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= '0;
    else if (!csb)           idle_cnt <= '0;
    else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
  end

  a_r8_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    csb |-> (!sdo_oe && !sdio_oe));

  a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  // R7: once deselected long enough, no register may change
  a_r7_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && idle_cnt >= 3'd6) |=> $stable(cfg_o));

  a_r9_srst_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[SRST_BIT] == 1'b0);

  a_r11_lock_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[LOCK_BIT] == 1'b0);
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csb     (csb),
  .sdo_oe  (sdo_oe),
  .sdio_oe (sdio_oe),
  .cfg_o   (cfg_o)
);

// File: tb/spi_reg_port_bench.sv
`timescale 1ns/1ps
module spi_reg_port_bench;
  localparam int HP = 6;   // core clocks per SCLK half period

  logic         clk = 1'b0;
  logic         rst_n, sclk, csb, sdio_in, lock_in;
  logic         sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [255:0] cfg_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [32];
  logic [7:0] wq  [4];

  always #2 clk = ~clk;

  spi_reg_port u_spi_reg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .lock_in(lock_in), .cfg_o(cfg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    int bad = 0;
    tests++;
    for (int a = 0; a < 32; a++) begin
      if (cfg_o[a*8 +: 8] !== mdl[a]) begin
        bad++;
        $display("FAIL %s: reg %0h actual %0h expected %0h", req, a, cfg_o[a*8 +: 8], mdl[a]);
      end
    end
    if (bad != 0) fails++;
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    logic [7:0] v = mdl[a];
    if (a == 0) v[1] = lock_in;
    return v;
  endfunction

  function automatic void mwrite(input int a, input logic [7:0] d);
    if (a == 0) begin
      if (d[5]) for (int i = 1; i < 32; i++) mdl[i] = 8'h00;
      mdl[0] = d & 8'hDD;
    end else begin
      mdl[a] = d;
    end
  endfunction

  task automatic sbit(input logic b, output logic rb);
    sdio_in = b;
    repeat (HP) @(negedge clk);
    rb = mdl[0][7] ? sdio_out : sdo_out;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v, input bit is_rd, output logic [7:0] r, output bit oe_ok);
    bit lsb = mdl[0][6];
    bit tw  = mdl[0][7];
    logic rb;
    oe_ok = 1'b1;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      if (is_rd) oe_ok &= tw ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe);
      sbit(v[idx], rb);
      r[idx] = rb;
    end
  endtask

  task automatic end_cycle(input string req);
    repeat (HP) @(negedge clk);
    csb = 1'b1;
    repeat (2*HP) @(negedge clk);
    chk({req, "/R8 idle enables"}, {30'd0, sdo_oe, sdio_oe}, 32'd0);
  endtask

  task automatic wr(input int a, input int n, input int extra, input string req);
    logic [7:0] r; bit ok; int cur; bit l;
    csb = 1'b0;
    repeat (HP) @(negedge clk);
    sbyte({1'b0, 2'(n-1), 5'(a)}, 1'b0, r, ok);
    cur = a;
    for (int k = 0; k < n; k++) begin
      l = mdl[0][6];
      sbyte(wq[k], 1'b0, r, ok);
      mwrite(cur, wq[k]);
      cur = l ? (cur + 1) % 32 : (cur + 31) % 32;
    end
    for (int k = 0; k < extra; k++) sbyte(8'hEE, 1'b0, r, ok);
    end_cycle(req);
  endtask

  task automatic rd(input int a, input int n, input string req);
    logic [7:0] r; bit ok; int cur;
    csb = 1'b0;
    repeat (HP) @(negedge clk);
    sbyte({1'b1, 2'(n-1), 5'(a)}, 1'b0, r, ok);
    cur = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = exp_rd(cur);
      sbyte(8'h00, 1'b1, r, ok);
      chk({req, " read data"}, {24'd0, r}, {24'd0, e});
      chk({req, "/R6 drive enables"}, {31'd0, ok}, 32'd1);
      cur = mdl[0][6] ? (cur + 1) % 32 : (cur + 31) % 32;
    end
    end_cycle(req);
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
  endtask

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + 11) ^ s);
  endfunction

  initial begin
    logic [7:0] r; bit ok;
    sclk = 1'b0; csb = 1'b1; sdio_in = 1'b0; lock_in = 1'b1;
    hard_reset();
    // R10: reset state
    chk_all("R10 reset state");
    chk("R8 enables after reset", {30'd0, sdo_oe, sdio_oe}, 32'd0);

    // R1 R2 R3: MSB-first burst sweep over 1Fh..01h
    for (int s = 31; s >= 7; s -= 4) begin
      for (int k = 0; k < 4; k++) wq[k] = pat(s - k, 0);
      wr(s, 4, 0, "R2 msb sweep write");
    end
    for (int k = 0; k < 3; k++) wq[k] = pat(3 - k, 0);
    wr(3, 3, 0, "R2 msb sweep write");
    chk_all("R2 R3 msb sweep contents");
    for (int s = 31; s >= 3; s -= 4) rd(s, 4, "R1 R5 msb sweep");

    // R4: switch to LSB-first and sweep 01h..1Fh
    wq[0] = 8'h40; wr(0, 1, 0, "R4 set lsb");
    for (int s = 1; s <= 25; s += 4) begin
      for (int k = 0; k < 4; k++) wq[k] = pat(s + k, 8'h5A);
      wr(s, 4, 0, "R4 lsb sweep write");
    end
    for (int k = 0; k < 3; k++) wq[k] = pat(29 + k, 8'h5A);
    wr(29, 3, 0, "R4 lsb sweep write");
    chk_all("R4 lsb sweep contents");
    for (int s = 0; s <= 28; s += 4) rd(s, 4, "R4 R5 lsb sweep");

    // R4: increment wrap 1Fh -> 00h
    wq[0] = 8'hA1; wq[1] = 8'hA2; wq[2] = 8'h40; wq[3] = 8'hA3;
    wr(30, 4, 0, "R4 wrap write");
    chk_all("R4 wrap 1Fh to 00h");

    // R6: 3-wire read path
    wq[0] = 8'hC0; wr(0, 1, 0, "R6 set 3-wire");
    rd(30, 2, "R6 3-wire read");
    wq[0] = 8'h00; wr(0, 1, 0, "R6 back to 4-wire msb");
    rd(4, 2, "R6 4-wire read");

    // R3: decrement wrap 00h -> 1Fh
    wq[0] = 8'h05; wq[1] = 8'h00; wq[2] = 8'h07;
    wr(1, 3, 0, "R3 wrap write");
    chk_all("R3 wrap 00h to 1Fh");

    // R12: order change mid-cycle
    wq[0] = 8'h40; wq[1] = 8'h3C;
    wr(0, 2, 0, "R12 mid-cycle order");
    chk_all("R12 mid-cycle order contents");
    wq[0] = 8'h00; wr(0, 1, 0, "R12 restore msb");

    // R7: aborted cycle
    csb = 1'b0;
    repeat (HP) @(negedge clk);
    sbyte({1'b0, 2'd1, 5'h10}, 1'b0, r, ok);
    sbyte(8'h77, 1'b0, r, ok);
    mwrite(16, 8'h77);
    for (int i = 0; i < 5; i++) begin
      logic rb;
      sbit(1'b1, rb);
    end
    end_cycle("R7 abort");
    chk_all("R7 partial byte discarded");
    rd(16, 2, "R7 restart after abort");

    // R13: surplus bits ignored
    wq[0] = 8'h3E; wr(8, 1, 2, "R13 extra bytes");
    chk_all("R13 extra bytes ignored");

    // R11: read-only lock bit
    lock_in = 1'b0;
    wq[0] = 8'h02; wr(0, 1, 0, "R11 write lock bit");
    chk("R11 lock bit not stored", {24'd0, cfg_o[7:0]}, 32'h00);
    rd(0, 1, "R11 lock low");
    lock_in = 1'b1;
    rd(0, 1, "R11 lock high");

    // R9: software reset
    wq[0] = 8'h24; wr(0, 1, 0, "R9 soft reset");
    chk_all("R9 soft reset contents");
    rd(0, 1, "R9 srst reads zero");

    // R10: hard reset clears 00h too
    wq[0] = 8'h99; wr(5, 1, 0, "R10 preload");
    wq[0] = 8'h80; wr(0, 1, 0, "R10 preload ctrl");
    hard_reset();
    chk_all("R10 hard reset clears all");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule